// File: doc/BRIEF.md
# Buffer-Ready and DMA Request Generator

This block sits beside the data FIFO of a storage-card host controller. It decides, after every command issue and every data-port access, whether the FIFO should be serviced by the CPU or by a DMA engine. It raises a CPU-visible flag and an interrupt event, or a DMA request line, and it clears whatever no longer applies. The decision uses four inputs: whether a transfer is active, the data direction, whether DMA mode is selected, and the current FIFO occupancy.

The surrounding controller pulses `eval_i` for one clock whenever the decision must be recomputed. One clock later the block updates its two present-state flags and its two DMA request lines, which then hold until the next pulse. In that same clock it emits one-cycle set/clear strobes toward the interrupt status and pending registers. Those registers live outside the block. Event index 1 is the read-ready event and index 0 is the write-ready event.

Top module: `bufrdy_dma_gen`

## Requirements
- R1: While `rst` is high, and after it is released until the first evaluation, every output is 0.
- R2: Idle case, taken when `xfer_active_i`=0 and `fifo_words_i`=0, whatever the direction and DMA mode. Both flags go low. Pending-clear and status-clear strobes are 11 and set strobes are 00. Both DMA request lines keep their previous values.
- R3: Read ready in CPU mode, taken when the transfer is active or the FIFO is non-empty, `card_to_host_i`=1, `fifo_words_i`>0 and `dma_mode_i`=0. `rd_avail_o` goes to 1, the pending-set strobe for bit 1 fires and bit 1 gets no clear. `dma_rd_req_o` keeps its value.
- R4: Read ready in DMA mode, with the R3 conditions but `dma_mode_i`=1. `dma_rd_req_o` goes to 1 and `dma_wr_req_o` goes to 0. Both flags go low. Both events get pending-clear and status-clear strobes (11) and no set strobes.
- R5: Write ready in CPU mode, taken when `xfer_active_i`=1, `card_to_host_i`=0, `fifo_words_i`=0 and `dma_mode_i`=0. `wr_space_o` goes to 1, the pending-set strobe for bit 0 fires and bit 0 gets no clear. `dma_wr_req_o` keeps its value. The read lane is cleared: `rd_avail_o`=0, `dma_rd_req_o`=0, and bit 1 is cleared in pending and status.
- R6: Write ready in DMA mode, with the R5 conditions but `dma_mode_i`=1. `dma_wr_req_o` goes to 1 and `dma_rd_req_o` goes to 0. Both flags go low and both events are cleared with no set.
- R7: A lane whose ready condition fails outside the idle case drops its flag and its DMA line to 0 and strobes clear for its event in pending and status. This covers the read direction with an empty FIFO and the write direction with a non-empty FIFO.
- R8: Strobes are high only in the cycle after an `eval_i` pulse. Flags and DMA lines do not change between pulses, even when the inputs change.
- R9: A set strobe and a clear strobe never fire for the same event together. The two flags are never both high, and the two DMA lines are never both high.
- R10: The FIFO holds 256 words. `fifo_words_i` ranges over 0..256, and a full count of 256 counts as non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | One-cycle request to recompute the decision |
| xfer_active_i | input | 1 | A data transfer is in progress |
| card_to_host_i | input | 1 | 1 = read from card, 0 = write to card |
| dma_mode_i | input | 1 | FIFO is serviced by DMA instead of the CPU |
| fifo_words_i | input | 9 | Current FIFO occupancy in words (0..256) |
| rd_avail_o | output | 1 | Present-state flag: data may be read from the buffer |
| wr_space_o | output | 1 | Present-state flag: data may be written to the buffer |
| dma_rd_req_o | output | 1 | DMA request for the read direction |
| dma_wr_req_o | output | 1 | DMA request for the write direction |
| evt_pend_set_o | output | 2 | Set strobes to pending register (1 = read-ready, 0 = write-ready) |
| evt_pend_clr_o | output | 2 | Clear strobes to pending register |
| evt_stat_clr_o | output | 2 | Clear strobes to status register |

## Verification
The bench targets cases where a DMA line must hold rather than move. After a DMA-mode read, switching to CPU mode must leave `dma_rd_req_o` high while `rd_avail_o` rises. An idle evaluation must keep that line high as well. A design that lowered it eagerly, or let idle override the DMA lines, would show a mismatch. The bench also checks that idle wins over DMA mode, that a full count of 256 is taken as non-empty (a design narrowing the count would see it as empty), and that input changes without an evaluation pulse move no output.

// File: rtl/bufrdy_pkg.sv
package bufrdy_pkg;

    localparam int FIFO_WORDS_DEF = 256;

    typedef enum logic {
        LANE_WR = 1'b0,
        LANE_RD = 1'b1
    } lane_e;

    typedef struct packed {
        logic flag;
        logic dma_drive;
        logic dma_val;
        logic pend_set;
        logic pend_clr;
        logic stat_clr;
    } lane_ctl_t;

    function automatic logic lane_hit(input lane_e lane, input logic to_host,
                                      input logic empty);
        return (lane == LANE_RD) ? (to_host && !empty) : (!to_host && empty);
    endfunction

endpackage

// File: rtl/bufrdy_occ.sv
module bufrdy_occ #(
    parameter int FIFO_WORDS = 256,
    parameter int OCC_W      = $clog2(FIFO_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] words_i,
    output logic             empty_o
);
    assign empty_o = (words_i == '0);

    a_r10_occ_range: assert property (@(posedge clk) disable iff (rst)
        (int'(words_i) <= FIFO_WORDS))
        else $error("occupancy beyond depth");
endmodule

// File: rtl/bufrdy_lane.sv
module bufrdy_lane
    import bufrdy_pkg::*;
#(
    parameter lane_e LANE = LANE_RD
) (
    input  logic      idle_i,
    input  logic      to_host_i,
    input  logic      empty_i,
    input  logic      dma_mode_i,
    output lane_ctl_t ctl_o
);
    logic hit;
    assign hit = lane_hit(LANE, to_host_i, empty_i);

    always_comb begin
        ctl_o = '0;
        if (idle_i) begin
            ctl_o.pend_clr = 1'b1;
            ctl_o.stat_clr = 1'b1;
        end else if (hit && dma_mode_i) begin
            ctl_o.dma_drive = 1'b1;
            ctl_o.dma_val   = 1'b1;
            ctl_o.pend_clr  = 1'b1;
            ctl_o.stat_clr  = 1'b1;
        end else if (hit) begin
            ctl_o.flag     = 1'b1;
            ctl_o.pend_set = 1'b1;
        end else begin
            ctl_o.dma_drive = 1'b1;
            ctl_o.dma_val   = 1'b0;
            ctl_o.pend_clr  = 1'b1;
            ctl_o.stat_clr  = 1'b1;
        end
    end
endmodule

// File: rtl/bufrdy_regs.sv
module bufrdy_regs
    import bufrdy_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_i,
    input  lane_ctl_t        ctl_i [LANES],
    output logic [LANES-1:0] flag_o,
    output logic [LANES-1:0] dma_o,
    output logic [LANES-1:0] pend_set_o,
    output logic [LANES-1:0] pend_clr_o,
    output logic [LANES-1:0] stat_clr_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_o[g]     <= 1'b0;
                dma_o[g]      <= 1'b0;
                pend_set_o[g] <= 1'b0;
                pend_clr_o[g] <= 1'b0;
                stat_clr_o[g] <= 1'b0;
            end else if (eval_i) begin
                flag_o[g]     <= ctl_i[g].flag;
                if (ctl_i[g].dma_drive) dma_o[g] <= ctl_i[g].dma_val;
                pend_set_o[g] <= ctl_i[g].pend_set;
                pend_clr_o[g] <= ctl_i[g].pend_clr;
                stat_clr_o[g] <= ctl_i[g].stat_clr;
            end else begin
                pend_set_o[g] <= 1'b0;
                pend_clr_o[g] <= 1'b0;
                stat_clr_o[g] <= 1'b0;
            end
        end

        a_r9_set_clr_excl: assert property (@(posedge clk) disable iff (rst)
            !(pend_set_o[g] && pend_clr_o[g]))
            else $error("set and clear together");
    end

    a_r8_strobe_after_eval: assert property (@(posedge clk) disable iff (rst)
        (|{pend_set_o, pend_clr_o, stat_clr_o}) |-> $past(eval_i))
        else $error("strobe without evaluation");

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !$past(eval_i) |-> ($stable(flag_o) && $stable(dma_o)))
        else $error("state moved without evaluation");
endmodule

// File: rtl/bufrdy_dma_gen.sv
module bufrdy_dma_gen
    import bufrdy_pkg::*;
#(
    parameter int FIFO_WORDS = FIFO_WORDS_DEF,
    parameter int OCC_W      = $clog2(FIFO_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_i,
    input  logic             xfer_active_i,
    input  logic             card_to_host_i,
    input  logic             dma_mode_i,
    input  logic [OCC_W-1:0] fifo_words_i,
    output logic             rd_avail_o,
    output logic             wr_space_o,
    output logic             dma_rd_req_o,
    output logic             dma_wr_req_o,
    output logic [1:0]       evt_pend_set_o,
    output logic [1:0]       evt_pend_clr_o,
    output logic [1:0]       evt_stat_clr_o
);
    localparam int LANES = 2;

    logic             empty;
    logic             idle;
    lane_ctl_t        ctl [LANES];
    logic [LANES-1:0] flag;
    logic [LANES-1:0] dma;

    bufrdy_occ #(.FIFO_WORDS(FIFO_WORDS), .OCC_W(OCC_W)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .words_i (fifo_words_i),
        .empty_o (empty)
    );

    assign idle = !xfer_active_i && empty;

    for (genvar g = 0; g < LANES; g++) begin : g_dec
        bufrdy_lane #(.LANE(lane_e'(g))) u_lane (
            .idle_i     (idle),
            .to_host_i  (card_to_host_i),
            .empty_i    (empty),
            .dma_mode_i (dma_mode_i),
            .ctl_o      (ctl[g])
        );
    end

    bufrdy_regs #(.LANES(LANES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .eval_i     (eval_i),
        .ctl_i      (ctl),
        .flag_o     (flag),
        .dma_o      (dma),
        .pend_set_o (evt_pend_set_o),
        .pend_clr_o (evt_pend_clr_o),
        .stat_clr_o (evt_stat_clr_o)
    );

    assign rd_avail_o   = flag[LANE_RD];
    assign wr_space_o   = flag[LANE_WR];
    assign dma_rd_req_o = dma[LANE_RD];
    assign dma_wr_req_o = dma[LANE_WR];

    a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_avail_o, wr_space_o}))
        else $error("both buffer flags high");

    a_r9_dma_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_rd_req_o, dma_wr_req_o}))
        else $error("both DMA lines high");

    a_r4_dma_rise_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_rd_req_o) |-> (!rd_avail_o && evt_pend_clr_o == 2'b11))
        else $error("read DMA raised without clearing");

    a_r6_dma_rise_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_wr_req_o) |-> (!wr_space_o && evt_stat_clr_o == 2'b11))
        else $error("write DMA raised without clearing");

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(rd_avail_o || wr_space_o || dma_rd_req_o || dma_wr_req_o))
        else $error("state after reset not clear");
endmodule

// File: tb/bufrdy_dma_gen_tb_top.sv
module bufrdy_dma_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eval_i = 1'b0;
    logic       xfer_active_i = 1'b0;
    logic       card_to_host_i = 1'b0;
    logic       dma_mode_i = 1'b0;
    logic [8:0] fifo_words_i = '0;
    logic       rd_avail_o, wr_space_o, dma_rd_req_o, dma_wr_req_o;
    logic [1:0] evt_pend_set_o, evt_pend_clr_o, evt_stat_clr_o;

    always #10 clk = ~clk;

    bufrdy_dma_gen dut_i (
        .clk(clk), .rst(rst), .eval_i(eval_i),
        .xfer_active_i(xfer_active_i), .card_to_host_i(card_to_host_i),
        .dma_mode_i(dma_mode_i), .fifo_words_i(fifo_words_i),
        .rd_avail_o(rd_avail_o), .wr_space_o(wr_space_o),
        .dma_rd_req_o(dma_rd_req_o), .dma_wr_req_o(dma_wr_req_o),
        .evt_pend_set_o(evt_pend_set_o), .evt_pend_clr_o(evt_pend_clr_o),
        .evt_stat_clr_o(evt_stat_clr_o)
    );

    typedef struct {
        bit [9:0] v;
        string    tag;
    } exp_t;

    exp_t     sb_q[$];
    int       n_chk = 0;
    int       n_bad = 0;
    bit       armed = 1'b0;
    bit [9:0] hold_v = '0;
    bit       m_dma_rd = 1'b0;
    bit       m_dma_wr = 1'b0;
    bit       done = 1'b0;

    function automatic bit [9:0] actual();
        return {rd_avail_o, wr_space_o, dma_rd_req_o, dma_wr_req_o,
                evt_pend_set_o, evt_pend_clr_o, evt_stat_clr_o};
    endfunction

    task automatic compare(input bit [9:0] exp_v, input string tag);
        n_chk++;
        if (actual() !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, actual(), exp_v);
        end
    endtask

    // Independent model of one lane: hit, idle, dma mode -> fields
    task automatic lane_model(input bit hit, input bit idle, input bit de,
                              inout bit dma, output bit flag, output bit ps,
                              output bit pc, output bit sc);
        flag = 0; ps = 0; pc = 1; sc = 1;
        if (!idle) begin
            if (hit && de) dma = 1;
            else if (hit) begin flag = 1; ps = 1; pc = 0; sc = 0; end
            else dma = 0;
        end
    endtask

    task automatic apply(input bit xa, input bit dr, input bit de,
                         input int cnt, input string tag);
        bit empty, idle, rf, wf, rps, rpc, rsc, wps, wpc, wsc;
        exp_t e;
        empty = (cnt == 0);
        idle  = !xa && empty;
        lane_model(dr && !empty, idle, de, m_dma_rd, rf, rps, rpc, rsc);
        lane_model(!dr && empty, idle, de, m_dma_wr, wf, wps, wpc, wsc);
        e.v   = {rf, wf, m_dma_rd, m_dma_wr, rps, wps, rpc, wpc, rsc, wsc};
        e.tag = tag;
        sb_q.push_back(e);
        xfer_active_i  = xa;
        card_to_host_i = dr;
        dma_mode_i     = de;
        fifo_words_i   = 9'(cnt);
        eval_i         = 1'b1;
        @(negedge clk);
    endtask

    task automatic quiet(input int n);
        eval_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) armed <= eval_i && !rst;

    // Monitor: pops expected items after each evaluation, else checks hold
    always @(negedge clk) begin
        if (!rst) begin
            if (armed) begin
                if (sb_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8 actual=unexpected-eval expected=queued-item");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    compare(e.v, e.tag);
                    hold_v = {e.v[9:6], 6'b0};
                end
            end else begin
                compare(hold_v, "R8 hold");
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs clear in reset
        compare(10'b0, "R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        compare(10'b0, "R1 after release");
        apply(1, 1, 0, 5,   "R3 read cpu");
        apply(1, 1, 1, 5,   "R4 read dma");
        apply(1, 1, 0, 5,   "R3 read cpu dma held");
        quiet(2);
        apply(0, 1, 0, 0,   "R2 idle dma held");
        apply(1, 0, 1, 0,   "R6 write dma");
        apply(1, 0, 0, 3,   "R7 write nonempty");
        apply(1, 0, 0, 0,   "R5 write cpu");
        apply(1, 0, 1, 0,   "R6 write dma again");
        apply(1, 0, 0, 0,   "R5 write cpu dma held");
        apply(1, 1, 0, 0,   "R7 read empty");
        apply(1, 1, 0, 256, "R10 full read nonempty");
        apply(1, 0, 0, 256, "R10 full write not ready");
        quiet(1);
        // R8: inputs move without evaluation
        xfer_active_i = 1; card_to_host_i = 0; dma_mode_i = 1; fifo_words_i = 0;
        @(negedge clk);
        card_to_host_i = 1; fifo_words_i = 9'd7;
        repeat (3) @(negedge clk);
        apply(1, 1, 1, 1,   "R4 read dma one word");
        apply(0, 0, 1, 0,   "R2 idle overrides dma");
        apply(0, 1, 0, 2,   "R3 inactive but nonempty");
        quiet(3);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end
endmodule